// File: doc/BRIEF.md
# Transfer-Completion Sequencer with Descriptor Chaining

This block is the decision stage of a small event-triggered transfer engine. When an activation arrives it reads the descriptor at slot 0 and keeps that descriptor's mode byte and transfer count. It then waits for the datapath to report that a transfer step has finished. At each finished step it decrements the count and writes the new value back to the descriptor store. In the same cycle it decides whether to fetch the next descriptor in the chain or to end the sequence.

When the sequence ends, the block may also pulse two clear strobes, one for the activation-source flag and one for its enable bit, and it may raise a CPU interrupt request. The interrupt request is a sticky level that stays high until software acknowledges it. A small chain pointer selects which descriptor the engine uses. The descriptor store sits outside the block: it returns the mode byte and count for the slot the pointer names.

Mode byte layout used by this block: bit 7 enables chaining, bit 6 limits chaining to a count that has reached zero, and bit 5 requests an interrupt after every step. Bits 4:0 (transfer kind, destination mode and the reserved bits) belong to the datapath and are ignored here.

Top module: `xfer_chain_seq`

## Requirements
- R1: After reset the block is idle: `busy`=0, `desc_idx`=0, `irq`=0, and `cnt_wr`, `src_flag_clr`, `src_en_clr` and `seq_end` are 0.
- R2: A `start` pulse while idle raises `busy` at the next clock edge. The descriptor at slot 0 is loaded one cycle later, and the block then accepts steps.
- R3: Every accepted `step_done` drives `cnt_wr`=1 in the same cycle, with `cnt_wr_val` equal to the loaded count minus one modulo 2^CNT_W. A loaded count of 0 therefore gives all ones, which does not count as zero.
- R4: If mode bit 7 is 0, the step ends the sequence: `seq_end`=1 in the same cycle.
- R5: If bit 7 is 1 and bit 6 is 0, every step chains. `desc_idx` advances by one (modulo 2^IDX_W) at the next edge, `busy` stays 1, and the next descriptor is loaded.
- R6: If bits 7 and 6 are both 1, the step chains only when the decremented count is zero. Otherwise it ends the sequence.
- R7: A chained step pulses neither `src_flag_clr`, `src_en_clr` nor `seq_end`, and it sets no interrupt.
- R8: A non-chained step whose decremented count is zero pulses `src_flag_clr` and `src_en_clr` in that same cycle, and `irq` is 1 in that same cycle.
- R9: A non-chained step with a nonzero decremented count raises `irq` in the same cycle if bit 5 is 1, and leaves `irq` unchanged if bit 5 is 0. No clear strobe is pulsed in either case.
- R10: `irq` stays high until `irq_clr` is seen. If a new interrupt is set in the same cycle as `irq_clr`, the set wins.
- R11: After the step that ends a sequence, `desc_idx` is 0 and `busy` is 0 at the next edge.
- R12: Mode bits 4:0 have no effect on any output.
- R13: `step_done` has no effect while the block is not waiting for a step (idle or loading): no strobe, and `desc_idx` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Activation pulse |
| step_done | input | 1 | Transfer step finished |
| irq_clr | input | 1 | Interrupt acknowledge |
| desc_mode | input | 8 | Mode byte of descriptor at `desc_idx` |
| desc_count | input | CNT_W | Count of descriptor at `desc_idx` |
| desc_idx | output | IDX_W | Chain pointer |
| busy | output | 1 | Sequence in progress |
| cnt_wr | output | 1 | Write back count to descriptor at `desc_idx` |
| cnt_wr_val | output | CNT_W | Decremented count |
| src_flag_clr | output | 1 | Clear activation-source flag |
| src_en_clr | output | 1 | Clear activation enable bit |
| seq_end | output | 1 | This step ends the sequence |
| irq | output | 1 | Sticky CPU interrupt request |

## Verification
Two events can fall in the same cycle. The first is a completing step that raises the interrupt together with both clear strobes. The second is a software acknowledge arriving in that very cycle. The bench provokes the collision by driving `irq_clr` together with the final `step_done` while `irq` is already high. It judges that `irq` stays high after the edge, then confirms that a lone `irq_clr` afterwards drops it. Random descriptor chains mix this collision with chained steps, where no clear or interrupt may appear at all.

// File: rtl/xfer_chain_seq.sv
module xfer_chain_seq #(
  parameter int IDX_W = 2,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             step_done,
  input  logic             irq_clr,
  input  logic [7:0]       desc_mode,
  input  logic [CNT_W-1:0] desc_count,
  output logic [IDX_W-1:0] desc_idx,
  output logic             busy,
  output logic             cnt_wr,
  output logic [CNT_W-1:0] cnt_wr_val,
  output logic             src_flag_clr,
  output logic             src_en_clr,
  output logic             seq_end,
  output logic             irq
);

  localparam logic [1:0] S_IDLE = 2'd0;
  localparam logic [1:0] S_LOAD = 2'd1;
  localparam logic [1:0] S_RUN  = 2'd2;

  logic [1:0]       st;
  logic [2:0]       mode_q;
  logic [CNT_W-1:0] cnt_q;
  logic             irq_q;

  wire              step      = (st == S_RUN) && step_done;
  wire [CNT_W-1:0]  cnt_nx    = cnt_q - 1'b1;
  wire              cnt_zero  = (cnt_nx == '0);
  wire              chain     = mode_q[2] && (!mode_q[1] || cnt_zero);
  wire              take_chain = step && chain;
  wire              finish    = step && !chain;
  wire              complete  = finish && cnt_zero;
  wire              irq_set   = complete || (finish && mode_q[0]);

  assign busy         = (st != S_IDLE);
  assign cnt_wr       = step;
  assign cnt_wr_val   = cnt_nx;
  assign src_flag_clr = complete;
  assign src_en_clr   = complete;
  assign seq_end      = finish;
  assign irq          = irq_q || irq_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      mode_q   <= '0;
      cnt_q    <= '0;
      desc_idx <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st       <= S_LOAD;
          desc_idx <= '0;
        end
        S_LOAD: begin
          mode_q <= desc_mode[7:5];
          cnt_q  <= desc_count;
          st     <= S_RUN;
        end
        S_RUN: if (step) begin
          cnt_q <= cnt_nx;
          if (chain) begin
            desc_idx <= desc_idx + 1'b1;
            st       <= S_LOAD;
          end else begin
            desc_idx <= '0;
            st       <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_q <= 1'b0;
    else if (irq_set) irq_q <= 1'b1;
    else if (irq_clr) irq_q <= 1'b0;
  end

  // R5
  chain_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_chain |=> (busy && desc_idx == $past(desc_idx) + 1'b1));

  // R8
  clr_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_flag_clr |-> (src_en_clr && irq && seq_end));

  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  // R10
  irq_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !irq_set) |=> !irq_q);

  // R11
  end_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_end |=> (desc_idx == '0 && !busy));

  // R13
  idle_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_RUN) |=> $stable(desc_idx));

endmodule

// File: tb/xfer_chain_seq_tb.sv
`timescale 1ns/1ps
module xfer_chain_seq_tb;
  logic clk = 0, rst_n = 0;
  logic start = 0, step_done = 0, irq_clr = 0;
  logic [7:0] mode_mem [4];
  logic [7:0] cnt_mem  [4];
  logic [1:0] desc_idx;
  logic [7:0] cnt_wr_val;
  logic busy, cnt_wr, src_flag_clr, src_en_clr, seq_end, irq;
  int checks = 0, errs = 0;
  bit exp_irq = 0;

  always #2 clk = ~clk;

  xfer_chain_seq #(.IDX_W(2), .CNT_W(8)) u_dut (
    .clk, .rst_n, .start, .step_done, .irq_clr,
    .desc_mode(mode_mem[desc_idx]), .desc_count(cnt_mem[desc_idx]),
    .desc_idx, .busy, .cnt_wr, .cnt_wr_val, .src_flag_clr, .src_en_clr,
    .seq_end, .irq);

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic bit does_chain(input logic [7:0] m, input logic [7:0] nc);
    return m[7] && (!m[6] || nc == 8'd0);
  endfunction

  task automatic run_act(input bit clr_last);
    int ref_idx = 0;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    #1 chk("R2 busy after start", busy, 1);
    @(negedge clk);
    for (int s = 0; s < 16; s++) begin
      logic [7:0] m, nc;
      bit ch, fin, comp, set;
      m = mode_mem[ref_idx];
      nc = cnt_mem[ref_idx] - 8'd1;
      ch = does_chain(m, nc);
      fin = !ch;
      comp = fin && nc == 8'd0;
      set = comp || (fin && m[5]);
      step_done = 1;
      irq_clr = clr_last && fin;
      #1;
      chk("R5 pointer", desc_idx, ref_idx);
      chk("R3 write strobe", cnt_wr, 1);
      chk("R3 write value", cnt_wr_val, nc);
      chk(ch ? "R7 no flag clear" : "R8 flag clear", src_flag_clr, comp);
      chk(ch ? "R7 no enable clear" : "R8 enable clear", src_en_clr, comp);
      chk(m[7] ? "R6 chain decision" : "R4 end decision", seq_end, fin);
      chk(ch ? "R7 irq" : "R9 irq", irq, exp_irq || set);
      @(negedge clk);
      step_done = 0;
      if (set) exp_irq = 1;
      else if (irq_clr) exp_irq = 0;
      irq_clr = 0;
      cnt_mem[ref_idx] = nc;
      #1 chk("R10 irq after step", irq, exp_irq);
      if (ch) begin
        ref_idx = (ref_idx + 1) % 4;
        chk("R5 busy on chain", busy, 1);
        chk("R5 pointer advance", desc_idx, ref_idx);
        @(negedge clk);
      end else begin
        chk("R11 pointer home", desc_idx, 0);
        chk("R11 idle", busy, 0);
        return;
      end
    end
    errs++;
    $display("FAIL R5 chain did not end actual=16 expected<16");
  endtask

  task automatic ack;
    @(negedge clk) irq_clr = 1;
    @(negedge clk) irq_clr = 0;
    exp_irq = 0;
    #1 chk("R10 ack clears", irq, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 4; i++) begin mode_mem[i] = 0; cnt_mem[i] = 1; end
    #9 rst_n = 1;
    @(negedge clk);
    #1;
    chk("R1 busy", busy, 0); chk("R1 idx", desc_idx, 0); chk("R1 irq", irq, 0);
    chk("R1 strobes", {cnt_wr, src_flag_clr, src_en_clr, seq_end}, 0);

    @(negedge clk) step_done = 1;
    #1 chk("R13 idle step write", cnt_wr, 0);
    chk("R13 idle step end", seq_end, 0);
    @(negedge clk) step_done = 0;
    #1 chk("R13 idle step idx", desc_idx, 0);

    mode_mem[0] = 8'h80; cnt_mem[0] = 5;
    mode_mem[1] = 8'h20; cnt_mem[1] = 3;
    run_act(0);
    chk("R9 irq per step", irq, 1);
    ack();

    mode_mem[0] = 8'hC0; cnt_mem[0] = 2;
    mode_mem[1] = 8'h00; cnt_mem[1] = 1;
    run_act(0);
    chk("R6 no irq without zero", irq, 0);
    run_act(0);
    chk("R8 irq on completion", irq, 1);

    for (int i = 0; i < 4; i++) begin mode_mem[i] = 8'hC0; cnt_mem[i] = 1; end
    cnt_mem[0] = 0;
    run_act(1);
    chk("R3 wrap not zero", cnt_mem[0], 255);
    ack();

    mode_mem[0] = 8'h00; cnt_mem[0] = 1;
    run_act(0);
    mode_mem[0] = 8'h20; cnt_mem[0] = 1;
    run_act(1);
    chk("R10 set beats clear", irq, 1);
    ack();

    mode_mem[0] = 8'h1F; cnt_mem[0] = 2;
    run_act(0);
    chk("R12 low bits ignored", irq, 0);

    for (int n = 0; n < 40; n++) begin
      for (int i = 0; i < 4; i++) begin
        mode_mem[i] = 8'($urandom());
        cnt_mem[i]  = 8'($urandom_range(0, 3));
      end
      mode_mem[3][7] = 1'b0;
      run_act(($urandom() & 1) == 1);
      if (($urandom() & 3) == 0) ack();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule